// File: doc/BRIEF.md
# Interleaved Block-Fill Memory Model

A synthesizable, cycle-timed main-memory model that answers four-word block refill requests from a cache. The cache presents a block address with a valid/ready handshake. The model then returns the block's words one at a time on a response port. Each word comes with a one-cycle valid strobe, and the final word also carries a last flag.

A two-bit organization select picks how the refill is timed:
- **Serial:** a one-word-wide DRAM that pays a full access for every word.
- **Page:** a one-word-wide DRAM that pays a full access for the first word and a short column access for each later word in the open row.
- **Banked:** four word-interleaved banks that are all read in one access and then drain on back-to-back cycles.

The select is sampled only when a request is accepted. The contents are a register array that reset fills with a fixed arithmetic pattern, so a test can predict every word.

Back-pressure rules:
- The request side obeys valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` stays low for the whole refill.
- The response side has no ready. The consumer must take each word in the cycle its strobe is high.

Cycle 1 is the cycle right after the accepting edge. Timing uses 1 cycle for the address, 25 for a DRAM access, 8 for a page-mode column access, and 1 to return a word. From these, the first word always appears in cycle 27.

Top module: `blockfill_mem`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and `rsp_valid`, `rsp_last` and `rsp_data` are 0.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from cycle 1 through the cycle holding the last word, and it is 1 again in the cycle after that.
- R3: With select 2'b00 (serial), words appear in cycles 27, 52, 77 and 102.
- R4: With select 2'b01 (page), words appear in cycles 27, 35, 43 and 51.
- R5: With select 2'b10 (banked), words appear in cycles 27, 28, 29 and 30, one per cycle with no gap.
- R6: Select 2'b11 is timed exactly like serial.
- R7: Word w of block a (w = 0..3) is returned in ascending w order. It holds 32'hA5C30F00 XOR ((4*a + w) * 32'h9E3779B9), truncated to 32 bits. Word w lives in bank w.
- R8: `rsp_last` is 1 exactly with the fourth word and never otherwise.
- R9: The select is captured when a request is accepted. Changing it during a refill does not alter that refill's timing.
- R10: `rsp_data` is 0 in every cycle where `rsp_valid` is 0.
- R11: Holding `req_valid` high while a refill runs starts no extra refill: exactly four words are returned per accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also reloads the contents |
| org_sel | input | 2 | Organization select: 00 serial, 01 page, 10 banked, 11 serial |
| req_valid | input | 1 | Refill request present |
| req_ready | output | 1 | Model idle and able to take a request |
| req_addr | input | ADDR_W | Block address |
| rsp_valid | output | 1 | One-cycle strobe for a returned word |
| rsp_data | output | DATA_W | Returned word, zero when no strobe |
| rsp_last | output | 1 | Marks the fourth word of the block |

## Verification
The checker assumes the consumer takes every word on its strobe, because there is no response ready. It also assumes `req_valid` is a plain level that may stay high across a refill, and that `org_sel` may change at any time without breaking anything.

The bench sweeps all four select codes over every block address. It holds `req_valid` high through half the refills and drops it after one cycle for the rest. It flips the select mid-refill on a quarter of them. It always deasserts `req_valid` before the ready edge, so that each expected refill is exactly one accepted request.

// File: rtl/blockfill_pkg.sv
`timescale 1ns/1ps
package blockfill_pkg;

  typedef enum logic [1:0] {
    ORG_SERIAL = 2'b00,
    ORG_PAGE   = 2'b01,
    ORG_BANKED = 2'b10,
    ORG_RSVD   = 2'b11
  } org_e;

  // Reset contents of flat word index idx = block*WORDS + offset.
  function automatic logic [31:0] fill_word(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'h9E37_79B9;
    return 32'hA5C3_0F00 ^ prod;
  endfunction

endpackage

// File: rtl/bf_bank.sv
`timescale 1ns/1ps
module bf_bank #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int WORDS   = 4,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  import blockfill_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  // Contents are loaded by reset; the model carries no write traffic.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= DATA_W'(fill_word(int'(i * WORDS + BANK_ID)));
      end
    end
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/bf_sequencer.sv
`timescale 1ns/1ps
module bf_sequencer #(
  parameter int WORDS = 4,
  parameter int CNT_W = 7,
  parameter int FIRST = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [CNT_W-1:0]         step,
  output logic                     busy,
  output logic                     fire,
  output logic                     last,
  output logic [$clog2(WORDS)-1:0] word
);
  localparam int WI_W = $clog2(WORDS);

  logic [CNT_W-1:0] cnt_q, due_q, step_q;
  logic [WI_W-1:0]  word_q;
  logic             busy_q;

  assign busy = busy_q;
  assign word = word_q;
  assign fire = busy_q && (cnt_q == due_q);
  assign last = fire && (word_q == WI_W'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      due_q  <= '0;
      step_q <= '0;
      word_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(1);
      due_q  <= CNT_W'(FIRST);
      step_q <= step;
      word_q <= '0;
    end else if (busy_q) begin
      if (last) begin
        busy_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (fire) begin
          due_q  <= due_q + step_q;
          word_q <= word_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/blockfill_mem.sv
`timescale 1ns/1ps
module blockfill_mem #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int WORDS      = 4,
  parameter int ADDR_CYC   = 1,
  parameter int ACCESS_CYC = 25,
  parameter int PAGE_CYC   = 8,
  parameter int XFER_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        org_sel,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_last
);
  import blockfill_pkg::*;

  localparam int FIRST    = ADDR_CYC + ACCESS_CYC + XFER_CYC;
  localparam int MAX_STEP = (ACCESS_CYC > PAGE_CYC) ? ACCESS_CYC : PAGE_CYC;
  localparam int LAST_CYC = FIRST + (WORDS - 1) * MAX_STEP;
  localparam int CNT_W    = $clog2(LAST_CYC + 2);
  localparam int WI_W     = $clog2(WORDS);

  logic              busy, fire, last;
  logic [WI_W-1:0]   word;
  logic              start;
  logic [CNT_W-1:0]  step;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] bank_q [WORDS];

  assign req_ready = !busy;
  assign start     = req_valid && !busy;

  // Spacing between words for the organization chosen at acceptance.
  always_comb begin
    case (org_e'(org_sel))
      ORG_PAGE:   step = CNT_W'(PAGE_CYC);
      ORG_BANKED: step = CNT_W'(XFER_CYC);
      default:    step = CNT_W'(ACCESS_CYC);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (start) begin
      addr_q <= req_addr;
    end
  end

  bf_sequencer #(
    .WORDS (WORDS),
    .CNT_W (CNT_W),
    .FIRST (FIRST)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .step  (step),
    .busy  (busy),
    .fire  (fire),
    .last  (last),
    .word  (word)
  );

  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    bf_bank #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .WORDS   (WORDS),
      .BANK_ID (b)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_addr (addr_q),
      .rd_data (bank_q[b])
    );
  end

  assign rsp_valid = fire;
  assign rsp_last  = last;
  assign rsp_data  = fire ? bank_q[word] : '0;

endmodule

// File: rtl/blockfill_mem_chk.sv
`timescale 1ns/1ps
module blockfill_mem_chk #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        org_sel,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_last,
  input logic [DATA_W-1:0] rsp_data
);
  localparam int SEEN_W = $clog2(WORDS) + 1;

  logic [SEEN_W-1:0] seen_q;
  logic              banked_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q   <= '0;
      banked_q <= 1'b0;
    end else if (req_valid && req_ready) begin
      seen_q   <= '0;
      banked_q <= (org_sel == 2'b10);
    end else if (rsp_valid) begin
      seen_q <= seen_q + 1'b1;
    end
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_busy_while_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  p_ready_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |=> req_ready);

  p_banked_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (banked_q && rsp_valid && !rsp_last) |=> rsp_valid);

  p_last_on_fourth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && seen_q == SEEN_W'(WORDS - 1)) |-> rsp_last);

  p_last_only_fourth_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_last |-> (rsp_valid && seen_q == SEEN_W'(WORDS - 1)));

  p_quiet_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_data == '0));

endmodule

bind blockfill_mem blockfill_mem_chk #(
  .DATA_W (DATA_W),
  .WORDS  (WORDS)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .org_sel   (org_sel),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .rsp_last  (rsp_last),
  .rsp_data  (rsp_data)
);

// File: tb/blockfill_mem_tb.sv
`timescale 1ns/1ps
module blockfill_mem_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        org_sel = 2'b00;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_last;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  blockfill_mem u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .org_sel   (org_sel),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_last  (rsp_last)
  );

  function automatic logic [31:0] exp_word(input int a, input int w);
    logic [31:0] p;
    p = (a * 4 + w) * 32'h9E37_79B9;
    return 32'hA5C3_0F00 ^ p;
  endfunction

  function automatic int exp_step(input logic [1:0] m);
    case (m)
      2'b01:   return 8;
      2'b10:   return 1;
      default: return 25;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic refill(input logic [1:0] m, input int a, input bit hold, input bit flip);
    int          t_seen [8];
    logic [31:0] d_seen [8];
    bit          l_seen [8];
    int          k = 0;
    int          bad_ready = 0;
    int          bad_quiet = 0;
    int          lastc;
    string       treq;
    lastc = 27 + 3 * exp_step(m);
    treq = (m == 2'b00) ? "R3" : (m == 2'b01) ? "R4" : (m == 2'b10) ? "R5" : "R6";
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    org_sel   = m;
    req_addr  = ADDR_W'(a);
    req_valid = 1'b1;
    @(posedge clk);
    for (int c = 1; c <= lastc + 1; c++) begin
      @(negedge clk);
      if (!hold && c == 1) req_valid = 1'b0;
      if (c == lastc) req_valid = 1'b0;
      if (flip && c == 3) org_sel = m + 2'b01;
      if (rsp_valid) begin
        if (k < 8) begin
          t_seen[k] = c;
          d_seen[k] = rsp_data;
          l_seen[k] = rsp_last;
        end
        k++;
      end else if (rsp_data != '0 || rsp_last) begin
        bad_quiet++;
      end
      if (c <= lastc && req_ready) bad_ready++;
      if (c == lastc + 1) begin
        chk(req_ready == 1'b1, "R2", "ready after last", req_ready, 1);
      end
    end
    org_sel = m;
    chk(bad_ready == 0, "R2", "ready high during refill (cycles)", bad_ready, 0);
    chk(k == 4, "R11", "words per request", k, 4);
    chk(bad_quiet == 0, "R10", "nonzero data/last without strobe (cycles)", bad_quiet, 0);
    for (int w = 0; w < 4 && w < k; w++) begin
      if (flip)
        chk(t_seen[w] == 27 + w * exp_step(m), "R9", "word cycle after select change",
            t_seen[w], 27 + w * exp_step(m));
      else
        chk(t_seen[w] == 27 + w * exp_step(m), treq, "word cycle",
            t_seen[w], 27 + w * exp_step(m));
      chk(d_seen[w] == exp_word(a, w), "R7", "word data", d_seen[w], exp_word(a, w));
      chk(l_seen[w] == (w == 3), "R8", "last flag", l_seen[w], (w == 3));
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1", "valid in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0 && rsp_last == 1'b0, "R1", "strobe/last after reset",
        {rsp_valid, rsp_last}, 0);
    chk(rsp_data == '0, "R1", "data after reset", rsp_data, 0);
    for (int m = 0; m < 4; m++) begin
      for (int a = 0; a < (1 << ADDR_W); a++) begin
        refill(2'(m), a, a[0], (a % 4) == 3);
      end
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule